// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Table

This block is the software-facing register front end of an interrupt redirection controller with a parameterised number of input pins (24 by default). Software reaches every internal register through three word addresses: a select register, a data window and an end-of-interrupt port. The select register holds an index. A window access then reaches the internal register that index names: the identification word, the read-only version word, the arbitration word, or one 32-bit half of a pin's 64-bit redirection entry. Entry n is reached at index 0x10 + 2n for its lower half and 0x10 + 2n + 1 for its upper half.

The block owns the redirection table and presents every entry to the delivery engine on a flat bus, with entry n in bits [64n+63:64n]. The delivery engine may set or clear an entry's remote-pending flag. The block emits a one-cycle strobe when a write flips an entry's mask bit, and another when a written entry ends up level-triggered. An end-of-interrupt write hands the written vector to the delivery engine. Reads return data one cycle after the access, under a two-state read controller. State ST_IDLE moves to ST_RESP on an accepted read. ST_RESP stays in ST_RESP when a further read is accepted and returns to ST_IDLE otherwise. ST_IDLE stays in ST_IDLE when no read is accepted.

Top module: `irq_route_regwin`

## Requirements
- R1: After reset every entry reads as 0x0000_0000_0001_0000, with only the mask bit (bit 16) set. The select register and the ID are 0, and no read-valid, strobe or end-of-interrupt pulse is active.
- R2: Byte offset 0x00 is the select register. A write stores all 32 data bits, and a read at 0x00 returns the last value written.
- R3: Index 0x00 is the ID register. A window write stores data bits 27:24, and a read returns the ID in bits 27:24 with all other bits 0. Index 0x02 reads back the same ID, and writes to index 0x02 leave the ID unchanged.
- R4: Index 0x01 reads (pin count − 1) in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits 0. Writes to index 0x01 change nothing.
- R5: For a select value s ≥ 0x10, the entry number is (s − 0x10) >> 1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32. Window writes update exactly that half, and the new value appears on the entries bus one cycle after the write.
- R6: A lower-half write forces remote-pending (bit 14) to 0 whatever the data holds. An upper-half write leaves bits 31:0 unchanged, including remote-pending. The rp_set input sets bit 14 and the rp_clr input clears it, with set taking priority; a same-cycle software write decides the final value.
- R7: A window write whose entry number is at or beyond the pin count changes nothing. A window read at any unmapped index (0x03 to 0x0F, or entry numbers beyond the table) returns 0.
- R8: Only full-word accesses (byte enables 4'hF) at offsets 0x00, 0x10 and 0x40 are claimed, and bus_claim shows this in the same cycle. An unclaimed access changes no state and gives no read-valid.
- R9: One cycle after a window write that flips an entry's mask bit (bit 16), mask_chg_valid pulses for one cycle with the pin number and the new mask value. A write that leaves the mask bit unchanged gives no pulse.
- R10: One cycle after any entry write that leaves the trigger-mode bit (bit 15) at 1, lvl_edit_valid pulses with the pin number. The pulse does not depend on whether the value changed.
- R11: A write at offset 0x40 gives eoi_valid for one cycle, starting the next cycle, with eoi_vector equal to data bits 7:0. A read at 0x40 returns 0.
- R12: bus_rvalid is high exactly in the cycle after an accepted read, and bus_rdata then holds the value the register had when the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_claim | output | 1 | Access decoded and accepted (same cycle) |
| bus_rvalid | output | 1 | Read data valid (one cycle after the read) |
| bus_rdata | output | 32 | Read data |
| rp_set | input | NPINS | Per-pin request from the delivery engine to set remote-pending |
| rp_clr | input | NPINS | Per-pin request from the delivery engine to clear remote-pending |
| entries | output | NPINS*64 | All redirection entries, entry n at [64n+63:64n] |
| mask_chg_valid | output | 1 | Mask bit of an entry flipped |
| mask_chg_pin | output | IDX_W | Pin whose mask flipped |
| mask_chg_val | output | 1 | New mask value |
| lvl_edit_valid | output | 1 | A level-triggered entry was written |
| lvl_edit_pin | output | IDX_W | Pin of that entry |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Acknowledged vector |

## Verification
The window is driven with random mixes of select values: the fixed registers, both halves of in-range entries, indices just past the last pin and arbitrary bytes. Every read and write is checked against a bench model. This separates an off-by-one or swapped-half index from a correct decode, and a discarded out-of-range write from one aliased onto a real entry. Directed cases then cover the remaining checks. They show that remote-pending survives an upper-half write but not a lower-half write, even one with bit 14 set. They show that a write repeating the mask value raises no strobe. They also show that partial-width and off-map accesses leave the select register untouched.

// File: rtl/irw_pkg.sv
package irw_pkg;

    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_SEL,
        PORT_WIN,
        PORT_EOI
    } port_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_LO,
        TGT_HI
    } tgt_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rd_state_e;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ENTRY_W = 64;

    localparam int unsigned BIT_REMOTE = 14;
    localparam int unsigned BIT_TRIG   = 15;
    localparam int unsigned BIT_MASK   = 16;

    localparam logic [WORD_W-1:0] IDX_ID  = 32'h0000_0000;
    localparam logic [WORD_W-1:0] IDX_VER = 32'h0000_0001;
    localparam logic [WORD_W-1:0] IDX_ARB = 32'h0000_0002;
    localparam logic [WORD_W-1:0] IDX_TBL = 32'h0000_0010;

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NPINS  = 24,
    parameter int unsigned IDX_W  = 5,
    parameter logic [ADDR_W-1:0] OFS_SEL = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_WIN = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_EOI = 8'h40
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [WORD_W-1:0] sel_q,
    output logic              claim,
    output port_e             port,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);

    logic [WORD_W-1:0] rel;
    logic [WORD_W-1:0] ent;

    always_comb begin
        port = PORT_NONE;
        if (req_addr == OFS_SEL) begin
            port = PORT_SEL;
        end else if (req_addr == OFS_WIN) begin
            port = PORT_WIN;
        end else if (req_addr == OFS_EOI) begin
            port = PORT_EOI;
        end
        claim = req_valid && (req_be == 4'hF) && (port != PORT_NONE);
    end

    always_comb begin
        rel = sel_q - IDX_TBL;
        ent = rel >> 1;
        tgt = TGT_NONE;
        if (sel_q == IDX_ID) begin
            tgt = TGT_ID;
        end else if (sel_q == IDX_VER) begin
            tgt = TGT_VER;
        end else if (sel_q == IDX_ARB) begin
            tgt = TGT_ARB;
        end else if ((sel_q >= IDX_TBL) && (ent < NPINS)) begin
            tgt = rel[0] ? TGT_HI : TGT_LO;
        end
        idx = ent[IDX_W-1:0];
    end

endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    parameter int unsigned IDX_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_hi,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [NPINS-1:0]         rp_set,
    input  logic [NPINS-1:0]         rp_clr,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic                     rd_hi,
    output logic [WORD_W-1:0]        rd_data,
    output logic [NPINS*ENTRY_W-1:0] entries_flat,
    output logic                     mask_chg_valid,
    output logic [IDX_W-1:0]         mask_chg_pin,
    output logic                     mask_chg_val,
    output logic                     lvl_valid,
    output logic [IDX_W-1:0]         lvl_pin
);

    localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << BIT_MASK;
    localparam logic [WORD_W-1:0]  LO_KEEP   = ~(WORD_W'(1) << BIT_REMOTE);

    logic [ENTRY_W-1:0] ent_w [NPINS];
    logic [ENTRY_W-1:0] old_sel;
    logic [ENTRY_W-1:0] merged;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [ENTRY_W-1:0] e_q;
        logic [ENTRY_W-1:0] e_nxt;
        logic               hit;

        assign hit = wr_en && (wr_idx == IDX_W'(p));

        always_comb begin
            e_nxt = e_q;
            if (rp_clr[p]) begin
                e_nxt[BIT_REMOTE] = 1'b0;
            end
            if (rp_set[p]) begin
                e_nxt[BIT_REMOTE] = 1'b1;
            end
            if (hit) begin
                if (wr_hi) begin
                    e_nxt[ENTRY_W-1:WORD_W] = wr_data;
                end else begin
                    e_nxt[WORD_W-1:0] = wr_data & LO_KEEP;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q <= RST_ENTRY;
            end else begin
                e_q <= e_nxt;
            end
        end

        assign ent_w[p] = e_q;
        assign entries_flat[p*ENTRY_W +: ENTRY_W] = e_q;
    end

    always_comb begin
        old_sel = ent_w[wr_idx];
        if (wr_hi) begin
            merged = {wr_data, old_sel[WORD_W-1:0]};
        end else begin
            merged = {old_sel[ENTRY_W-1:WORD_W], wr_data & LO_KEEP};
        end
    end

    assign rd_data = rd_hi ? ent_w[rd_idx][ENTRY_W-1:WORD_W]
                           : ent_w[rd_idx][WORD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_val   <= 1'b0;
            lvl_valid      <= 1'b0;
            lvl_pin        <= '0;
        end else begin
            mask_chg_valid <= wr_en && (merged[BIT_MASK] != old_sel[BIT_MASK]);
            mask_chg_pin   <= wr_idx;
            mask_chg_val   <= merged[BIT_MASK];
            lvl_valid      <= wr_en && merged[BIT_TRIG];
            lvl_pin        <= wr_idx;
        end
    end

    // R6: a lower-half write leaves remote-pending clear
    p_lo_clears_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (ent_w[$past(wr_idx)][BIT_REMOTE] == 1'b0));

    // R6: an upper-half write without engine requests keeps the lower word
    p_hi_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && (rp_set == '0) && (rp_clr == '0))
        |=> (ent_w[$past(wr_idx)][WORD_W-1:0] == $past(old_sel[WORD_W-1:0])));

    // R9: the strobe value matches the stored mask bit
    p_mask_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (ent_w[mask_chg_pin][BIT_MASK] == mask_chg_val));

    // R10: a level-edit strobe only names a level-triggered entry
    p_lvl_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |-> ent_w[lvl_pin][BIT_TRIG]);

endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
    import irw_pkg::*;
#(
    parameter int unsigned NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  port_e             port,
    input  tgt_e              tgt,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] tbl_rdata,
    output logic [WORD_W-1:0] sel_q,
    output logic              tbl_wr_en,
    output logic              tbl_wr_hi,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);

    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    rd_state_e         state_q;
    rd_state_e         state_nxt;
    logic [3:0]        id_q;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] win_val;
    logic              rd_accept;
    logic              wr_accept;

    assign rd_accept = claim && !req_write;
    assign wr_accept = claim && req_write;

    assign tbl_wr_en = wr_accept && (port == PORT_WIN)
                       && ((tgt == TGT_LO) || (tgt == TGT_HI));
    assign tbl_wr_hi = (tgt == TGT_HI);

    always_comb begin
        unique case (tgt)
            TGT_ID, TGT_ARB: win_val = {4'h0, id_q, 24'h0};
            TGT_VER:         win_val = {8'h00, MAX_PIN, 8'h00, VERSION};
            TGT_LO, TGT_HI:  win_val = tbl_rdata;
            default:         win_val = '0;
        endcase
        unique case (port)
            PORT_SEL: rd_mux = sel_q;
            PORT_WIN: rd_mux = win_val;
            default:  rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: state_nxt = rd_accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = rd_accept ? ST_RESP : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rvalid = (state_q == ST_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            sel_q      <= '0;
            id_q       <= '0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            if (rd_accept) begin
                rdata <= rd_mux;
            end
            if (wr_accept && (port == PORT_SEL)) begin
                sel_q <= req_wdata;
            end
            if (wr_accept && (port == PORT_WIN) && (tgt == TGT_ID)) begin
                id_q <= req_wdata[27:24];
            end
            eoi_valid <= wr_accept && (port == PORT_EOI);
            if (wr_accept && (port == PORT_EOI)) begin
                eoi_vector <= req_wdata[7:0];
            end
        end
    end

    // R12: an accepted read is answered in the next cycle
    p_read_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |=> rvalid);

    // R12: no read-valid without a read
    p_no_spurious_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_accept));

    // R11: the end-of-interrupt pulse carries the written low byte
    p_eoi_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && (port == PORT_EOI)) |=> (eoi_valid && (eoi_vector == $past(req_wdata[7:0]))));

    // R3: arbitration writes leave the ID untouched
    p_arb_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && (port == PORT_WIN) && (tgt == TGT_ARB)) |=> $stable(id_q));

endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    parameter logic [ADDR_W-1:0] OFS_SEL = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_WIN = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_EOI = 8'h40,
    localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [3:0]                 bus_be,
    input  logic [31:0]                bus_wdata,
    output logic                       bus_claim,
    output logic                       bus_rvalid,
    output logic [31:0]                bus_rdata,
    input  logic [NPINS-1:0]           rp_set,
    input  logic [NPINS-1:0]           rp_clr,
    output logic [NPINS*64-1:0]        entries,
    output logic                       mask_chg_valid,
    output logic [IDX_W-1:0]           mask_chg_pin,
    output logic                       mask_chg_val,
    output logic                       lvl_edit_valid,
    output logic [IDX_W-1:0]           lvl_edit_pin,
    output logic                       eoi_valid,
    output logic [7:0]                 eoi_vector
);

    port_e             port;
    tgt_e              tgt;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] sel_q;
    logic [WORD_W-1:0] tbl_rdata;
    logic              tbl_wr_en;
    logic              tbl_wr_hi;

    irw_decode #(
        .ADDR_W  (ADDR_W),
        .NPINS   (NPINS),
        .IDX_W   (IDX_W),
        .OFS_SEL (OFS_SEL),
        .OFS_WIN (OFS_WIN),
        .OFS_EOI (OFS_EOI)
    ) u_decode (
        .req_valid (bus_valid),
        .req_addr  (bus_addr),
        .req_be    (bus_be),
        .sel_q     (sel_q),
        .claim     (bus_claim),
        .port      (port),
        .tgt       (tgt),
        .idx       (idx)
    );

    irw_ctrl #(
        .NPINS   (NPINS),
        .VERSION (VERSION)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim      (bus_claim),
        .port       (port),
        .tgt        (tgt),
        .req_write  (bus_write),
        .req_wdata  (bus_wdata),
        .tbl_rdata  (tbl_rdata),
        .sel_q      (sel_q),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_wr_hi  (tbl_wr_hi),
        .rvalid     (bus_rvalid),
        .rdata      (bus_rdata),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector)
    );

    irw_table #(
        .NPINS (NPINS),
        .IDX_W (IDX_W)
    ) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (tbl_wr_en),
        .wr_hi          (tbl_wr_hi),
        .wr_idx         (idx),
        .wr_data        (bus_wdata),
        .rp_set         (rp_set),
        .rp_clr         (rp_clr),
        .rd_idx         (idx),
        .rd_hi          (tgt == TGT_HI),
        .rd_data        (tbl_rdata),
        .entries_flat   (entries),
        .mask_chg_valid (mask_chg_valid),
        .mask_chg_pin   (mask_chg_pin),
        .mask_chg_val   (mask_chg_val),
        .lvl_valid      (lvl_edit_valid),
        .lvl_pin        (lvl_edit_pin)
    );

    // R7: a window write past the table end leaves every entry unchanged
    p_oob_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_claim && bus_write && (port == PORT_WIN) && (tgt == TGT_NONE)
         && (rp_set == '0) && (rp_clr == '0)) |=> $stable(entries));

    // R8: an unclaimed access changes no state and gives no read data
    p_unclaimed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_claim && (rp_set == '0) && (rp_clr == '0))
        |=> (!bus_rvalid && $stable(entries) && $stable(sel_q)));

endmodule

// File: tb/irq_route_regwin_tb.sv
`timescale 1ns/1ps
module irq_route_regwin_tb;

    localparam int NP = 24;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [3:0]      bus_be = 4'hF;
    logic [31:0]     bus_wdata = '0;
    logic            bus_claim;
    logic            bus_rvalid;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   rp_set = '0;
    logic [NP-1:0]   rp_clr = '0;
    logic [NP*64-1:0] entries;
    logic            mask_chg_valid;
    logic [IW-1:0]   mask_chg_pin;
    logic            mask_chg_val;
    logic            lvl_edit_valid;
    logic [IW-1:0]   lvl_edit_pin;
    logic            eoi_valid;
    logic [7:0]      eoi_vector;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_ent [NP];
    logic [31:0] m_sel;
    logic [3:0]  m_id;

    always #5 clk = ~clk;

    irq_route_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_claim(bus_claim), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .rp_set(rp_set), .rp_clr(rp_clr), .entries(entries),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_val(mask_chg_val), .lvl_edit_valid(lvl_edit_valid),
        .lvl_edit_pin(lvl_edit_pin), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ent_of(input logic [31:0] s);
        if (s < 32'h10) return -1;
        if (((s - 32'h10) >> 1) >= NP) return -1;
        return int'((s - 32'h10) >> 1);
    endfunction

    function automatic logic [31:0] exp_win(input logic [31:0] s);
        int e;
        e = ent_of(s);
        if (s == 0 || s == 2) return {4'h0, m_id, 24'h0};
        if (s == 1) return 32'h0017_0011;
        if (e < 0) return 32'h0;
        return s[0] ? m_ent[e][63:32] : m_ent[e][31:0];
    endfunction

    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'hF;
    endtask

    task automatic chk_entries(input string req);
        for (int p = 0; p < NP; p++) chk(req, entries[p*64 +: 64], m_ent[p]);
    endtask

    task automatic wr_sel(input logic [31:0] s);
        op(1'b1, 8'h00, s, 4'hF);
        m_sel = s;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        op(1'b0, a, 32'h0, 4'hF);
        chk(req, {63'h0, bus_rvalid}, 64'h1);
        chk(req, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic wr_win(input logic [31:0] d);
        int e;
        logic [63:0] nv;
        e = ent_of(m_sel);
        nv = (e >= 0) ? m_ent[e] : 64'h0;
        if (e >= 0) begin
            if (m_sel[0]) nv[63:32] = d;
            else begin nv[31:0] = d; nv[14] = 1'b0; end
        end
        op(1'b1, 8'h10, d, 4'hF);
        if (e >= 0) begin
            chk("R9 mask strobe", {63'h0, mask_chg_valid}, {63'h0, nv[16] != m_ent[e][16]});
            if (nv[16] != m_ent[e][16]) begin
                chk("R9 mask pin", {59'h0, mask_chg_pin}, 64'(e));
                chk("R9 mask val", {63'h0, mask_chg_val}, {63'h0, nv[16]});
            end
            chk("R10 level strobe", {63'h0, lvl_edit_valid}, {63'h0, nv[15]});
            if (nv[15]) chk("R10 level pin", {59'h0, lvl_edit_pin}, 64'(e));
            m_ent[e] = nv;
            chk("R5 entry update", entries[e*64 +: 64], nv);
        end else begin
            if (m_sel == 0) m_id = d[27:24];
            chk("R7 no strobe", {62'h0, mask_chg_valid, lvl_edit_valid}, 64'h0);
            if (m_sel >= 32'h10) chk_entries("R7 discarded write");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        for (int p = 0; p < NP; p++) m_ent[p] = 64'h0000_0000_0001_0000;
        m_sel = '0;
        m_id = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_entries("R1 reset entries");
        chk("R1 idle outputs", {60'h0, bus_rvalid, mask_chg_valid, lvl_edit_valid, eoi_valid}, 64'h0);
        rd_chk(8'h00, 32'h0, "R1 select reset");
        rd_chk(8'h10, 32'h0, "R1 id reset");

        // R2 select readback
        wr_sel(32'hDEAD_BEEF);
        rd_chk(8'h00, 32'hDEAD_BEEF, "R2 select readback");

        // R3 id and arbitration
        wr_sel(32'h0);
        wr_win(32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0F00_0000, "R3 id read");
        wr_sel(32'h2);
        wr_win(32'h0000_0000);
        rd_chk(8'h10, 32'h0F00_0000, "R3 arb reads id, write ignored");

        // R4 version
        wr_sel(32'h1);
        wr_win(32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0017_0011, "R4 version");
        wr_sel(32'h0);
        rd_chk(8'h10, 32'h0F00_0000, "R4 version write left id alone");

        // R5 halves, R9 mask flip and no-flip, R10 level
        wr_sel(32'h10 + 2*5);
        wr_win(32'h0000_A0B1);
        wr_win(32'h0000_A0B1);
        wr_sel(32'h10 + 2*5 + 1);
        wr_win(32'h7700_0000);
        rd_chk(8'h10, 32'h7700_0000, "R5 high half");
        wr_sel(32'h10 + 2*5);
        rd_chk(8'h10, 32'h0000_A0B1, "R5 low half");
        wr_win(32'h0001_8031);

        // R6 remote-pending
        @(negedge clk); rp_set = NP'(1) << 3;
        @(negedge clk); rp_set = '0;
        m_ent[3][14] = 1'b1;
        chk("R6 engine set", entries[3*64 +: 64], m_ent[3]);
        wr_sel(32'h10 + 2*3 + 1);
        wr_win(32'h1200_0000);
        chk("R6 high write keeps remote", {63'h0, entries[3*64+14]}, 64'h1);
        wr_sel(32'h10 + 2*3);
        wr_win(32'h0000_4055);
        chk("R6 low write clears remote", {63'h0, entries[3*64+14]}, 64'h0);
        @(negedge clk); rp_set = NP'(1) << 7;
        @(negedge clk); rp_set = '0; rp_clr = NP'(1) << 7;
        @(negedge clk); rp_clr = '0;
        chk("R6 engine clear", {63'h0, entries[7*64+14]}, 64'h0);

        // R7 out of range
        wr_sel(32'h10 + 2*NP);
        wr_win(32'h0000_0000);
        rd_chk(8'h10, 32'h0, "R7 out-of-range read");
        wr_sel(32'h5);
        rd_chk(8'h10, 32'h0, "R7 unmapped index read");

        // R8 unclaimed
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h55;
        #1 chk("R8 off-map not claimed", {63'h0, bus_claim}, 64'h0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_be = 4'h3;
        #1 chk("R8 partial not claimed", {63'h0, bus_claim}, 64'h0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h30; bus_be = 4'hF;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R8 no rvalid", {63'h0, bus_rvalid}, 64'h0);
        rd_chk(8'h00, m_sel, "R8 select untouched");

        // R11 end of interrupt
        op(1'b1, 8'h40, 32'h0000_01A5, 4'hF);
        chk("R11 eoi pulse", {63'h0, eoi_valid}, 64'h1);
        chk("R11 eoi vector", {56'h0, eoi_vector}, 64'hA5);
        @(negedge clk);
        chk("R11 eoi one cycle", {63'h0, eoi_valid}, 64'h0);
        rd_chk(8'h40, 32'h0, "R11 eoi read");

        // R12 back-to-back reads
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h00;
        @(negedge clk);
        chk("R12 first rvalid", {63'h0, bus_rvalid}, 64'h1);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R12 second rvalid", {32'h0, bus_rvalid, bus_rdata[30:0]}, {32'h0, 1'b1, m_sel[30:0]});
        @(negedge clk);
        chk("R12 rvalid drops", {63'h0, bus_rvalid}, 64'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom % 5);
            if (k == 0) begin
                int r;
                r = int'($urandom % 4);
                if (r == 0) wr_sel($urandom % 3);
                else if (r == 3) wr_sel($urandom % 256);
                else wr_sel(32'h10 + ($urandom % 52));
            end else if (k == 1 || k == 2) begin
                wr_win($urandom);
            end else if (k == 3) begin
                rd_chk(8'h10, exp_win(m_sel), "R5 random window read");
            end else begin
                logic [31:0] v;
                v = $urandom;
                op(1'b1, 8'h40, v, 4'hF);
                chk("R11 random eoi", {55'h0, eoi_valid, eoi_vector}, {55'h0, 1'b1, v[7:0]});
            end
        end
        chk_entries("R5 final table");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule